// File: doc/BRIEF.md
# Lazy Condition-Code Flag Evaluator

This block keeps the condition flags of a 32-bit processor in deferred form. The datapath does not produce N, Z, V and C directly. Instead it records three things: an operation-class code, the second source operand and the result. The block rebuilds the four flags from that record whenever they are observed. The rebuilt flags are merged with a separately held extend bit and the upper bits of a 16-bit status register, and the merged value appears on `status_o` at all times.

The block also runs multi-precision add and subtract with extend. It forms the result and the new extend bit from two operands and the current extend bit. It rebuilds the flags of that result and keeps the zero flag sticky, so a chain of such operations across several words reports zero only when every word was zero. A flush command collapses the pending record into direct flags without changing the visible value. A status write loads every bit at once. Only one command takes effect per cycle, chosen by a fixed priority.

Top module: `ccr_lazy_eval`

## Requirements
- R1: After reset, `status_o`, `ext_res_o` and `err_o` are all zero.
- R2: A record command stores class, source and result. Class codes are 0 direct, 1 logic, 2 add, 3 subtract, 4 byte compare, 5 word compare, 6 add-with-extend, 7 subtract-with-extend and 8 shift. For every class except direct, Z is set exactly when the result is zero, and N is set only when the result is nonzero and its sign bit is one. For logic, V and C are zero.
- R3: Class 2 (add, result = op1 + src): C is set when the result is unsigned-less than src. V is set on signed overflow of the addition.
- R4: Class 3 (subtract, result = op1 − src): C is set on unsigned borrow. V is set on signed overflow of the subtraction.
- R5: Classes 4 and 5 apply the subtract rules to the low 8 and low 16 bits only. N, Z, V and C are taken at bit 7 or bit 15, and higher bits of src and result have no effect.
- R6: Class 6 (result = op1 + src + 1) sets C when result ≤ src. Class 7 (result = op1 − src − 1) sets C when op1 ≤ src. V follows signed overflow of the operation including the extra one.
- R7: Class 8 (shift) sets C when the stored source is nonzero, clears V, and applies the N/Z rule of R2 to the result.
- R8: An extended operation with X clear computes op_a ± op_b. With X set it computes op_a + op_b + 1 or op_a − op_b − 1. The new X is the carry or borrow of that operation. The result appears on `ext_res_o` one cycle later.
- R9: After an extended operation, the new Z is the result-zero test ANDed with the previous Z. N, V and C come from the new result.
- R10: `status_o` bit 0 is C, bit 1 V, bit 2 Z, bit 3 N, and bit 4 is X. Bits 15..5 change only on a status write. A direct-class record takes the flags from result bits 3..0.
- R11: A record with a class code from 9 to 15 leaves `status_o` unchanged and raises `err_o` for exactly the following cycle.
- R12: A flush leaves `status_o` unchanged and turns the pending record into direct flags.
- R13: Priority among commands in one cycle is status write, then extended operation, then record, then flush. Lower-priority commands in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_wr_valid | input | 1 | Load the whole status register |
| sr_wr_data | input | 16 | Status value to load |
| ext_valid | input | 1 | Start an extended add or subtract |
| ext_sub | input | 1 | 1 selects subtract for the extended operation |
| ext_a | input | 32 | First operand of the extended operation |
| ext_b | input | 32 | Second operand of the extended operation |
| rec_valid | input | 1 | Record a deferred flag state |
| rec_class | input | 4 | Operation-class code of the record |
| rec_src | input | 32 | Saved source operand |
| rec_res | input | 32 | Saved result |
| flush_valid | input | 1 | Collapse the pending record into direct flags |
| status_o | output | 16 | Merged status register with live flags |
| ext_res_o | output | 32 | Result of the last extended operation |
| err_o | output | 1 | One-cycle pulse after a rejected class code |

## Verification
The hardest behaviour to reach is the sticky zero flag across a multi-word chain. It needs the extend bit and Z prepared, then a chain in which an early word is nonzero and a later word is zero, and the ports show only the merged Z. The bench prepares both bits with a status write and then runs extended operations back to back, with nonzero words first and zero words after them, and with X in both states. The narrowed compares are driven with upper bits that would give the opposite flags if they were used.

// File: rtl/ccr_lazy_pkg.sv
package ccr_lazy_pkg;

    typedef enum logic [3:0] {
        CLS_DIRECT = 4'd0,
        CLS_LOGIC  = 4'd1,
        CLS_ADD    = 4'd2,
        CLS_SUB    = 4'd3,
        CLS_CMPB   = 4'd4,
        CLS_CMPW   = 4'd5,
        CLS_ADDX   = 4'd6,
        CLS_SUBX   = 4'd7,
        CLS_SHIFT  = 4'd8
    } cc_class_e;

    localparam int FLG_C = 0;
    localparam int FLG_V = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_N = 3;
    localparam int SR_X  = 4;
    localparam int NFLG  = 4;

    function automatic logic class_known(input logic [3:0] code);
        return code <= CLS_SHIFT;
    endfunction

endpackage

// File: rtl/ccr_sub_rule.sv
// Subtract-style flag rule at width W: rebuild op1 = res + src + CIN.
module ccr_sub_rule #(
    parameter int W   = 32,
    parameter int CIN = 0
) (
    input  logic [W-1:0] src,
    input  logic [W-1:0] res,
    output logic         n,
    output logic         z,
    output logic         c,
    output logic         v
);
    logic [W-1:0] op1;
    logic [W-1:0] ovf;

    always_comb begin
        op1 = res + src + W'(CIN);
        ovf = (op1 ^ res) & (op1 ^ src);
        z   = (res == '0);
        n   = !z && res[W-1];
        c   = (CIN != 0) ? (op1 <= src) : (op1 < src);
        v   = ovf[W-1];
    end
endmodule

// File: rtl/ccr_add_rule.sv
// Add-style flag rule at width W: rebuild op1 = res - src - CIN.
module ccr_add_rule #(
    parameter int W   = 32,
    parameter int CIN = 0
) (
    input  logic [W-1:0] src,
    input  logic [W-1:0] res,
    output logic         c,
    output logic         v
);
    logic [W-1:0] op1;
    logic [W-1:0] ovf;

    always_comb begin
        op1 = res - src - W'(CIN);
        ovf = (src ^ res) & ~(op1 ^ src);
        c   = (CIN != 0) ? (res <= src) : (res < src);
        v   = ovf[W-1];
    end
endmodule

// File: rtl/ccr_flag_eval.sv
module ccr_flag_eval
    import ccr_lazy_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]      cls,
    input  logic [DW-1:0]   src,
    input  logic [DW-1:0]   res,
    output logic [NFLG-1:0] flags,
    output logic            known
);
    localparam int NSUB = 3;

    logic [NSUB-1:0] sn, sz, sc, sv;
    logic            xn, xz, xc, xv;
    logic            ac, av, axc, axv;
    logic            fz, fn;

    // Narrow (8, 16) and full-width subtract rules.
    for (genvar g = 0; g < NSUB; g++) begin : g_sub
        localparam int SW = (g == NSUB - 1) ? DW : (8 << g);
        ccr_sub_rule #(.W(SW), .CIN(0)) u_rule (
            .src (src[SW-1:0]),
            .res (res[SW-1:0]),
            .n   (sn[g]),
            .z   (sz[g]),
            .c   (sc[g]),
            .v   (sv[g])
        );
    end

    ccr_sub_rule #(.W(DW), .CIN(1)) u_subx (
        .src (src), .res (res), .n (xn), .z (xz), .c (xc), .v (xv)
    );
    ccr_add_rule #(.W(DW), .CIN(0)) u_add (
        .src (src), .res (res), .c (ac), .v (av)
    );
    ccr_add_rule #(.W(DW), .CIN(1)) u_addx (
        .src (src), .res (res), .c (axc), .v (axv)
    );

    always_comb begin
        fz    = (res == '0);
        fn    = !fz && res[DW-1];
        known = 1'b1;
        flags = '0;
        case (cls)
            CLS_DIRECT: flags = res[NFLG-1:0];
            CLS_LOGIC:  flags = {fn, fz, 1'b0, 1'b0};
            CLS_ADD:    flags = {fn, fz, av, ac};
            CLS_SUB:    flags = {sn[2], sz[2], sv[2], sc[2]};
            CLS_CMPB:   flags = {sn[0], sz[0], sv[0], sc[0]};
            CLS_CMPW:   flags = {sn[1], sz[1], sv[1], sc[1]};
            CLS_ADDX:   flags = {fn, fz, axv, axc};
            CLS_SUBX:   flags = {xn, xz, xv, xc};
            CLS_SHIFT:  flags = {fn, fz, 1'b0, (src != '0)};
            default: begin
                known = 1'b0;
                flags = '0;
            end
        endcase
    end

    // R2: a rebuilt (non-direct) flag set never shows N and Z together
    always_comb begin
        if (known && cls != CLS_DIRECT) begin
            a_r2_nz_disjoint: assert (!(flags[FLG_N] && flags[FLG_Z]));
        end
    end
endmodule

// File: rtl/ccr_ext_alu.sv
module ccr_ext_alu
    import ccr_lazy_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          sub,
    input  logic          x_in,
    output logic [DW-1:0] res,
    output logic          x_out,
    output logic [3:0]    cls
);
    always_comb begin
        if (sub) begin
            res   = op_a - op_b - DW'(x_in);
            x_out = x_in ? (op_a <= op_b) : (op_a < op_b);
            cls   = x_in ? CLS_SUBX : CLS_SUB;
        end else begin
            res   = op_a + op_b + DW'(x_in);
            x_out = x_in ? (res <= op_b) : (res < op_b);
            cls   = x_in ? CLS_ADDX : CLS_ADD;
        end
    end
endmodule

// File: rtl/ccr_lazy_eval.sv
module ccr_lazy_eval
    import ccr_lazy_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SRW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sr_wr_valid,
    input  logic [SRW-1:0]  sr_wr_data,
    input  logic            ext_valid,
    input  logic            ext_sub,
    input  logic [DW-1:0]   ext_a,
    input  logic [DW-1:0]   ext_b,
    input  logic            rec_valid,
    input  logic [3:0]      rec_class,
    input  logic [DW-1:0]   rec_src,
    input  logic [DW-1:0]   rec_res,
    input  logic            flush_valid,
    output logic [SRW-1:0]  status_o,
    output logic [DW-1:0]   ext_res_o,
    output logic            err_o
);
    localparam int HIW = SRW - SR_X - 1;

    typedef struct packed {
        logic [3:0]     cls;
        logic [DW-1:0]  src;
        logic [DW-1:0]  res;
        logic [HIW-1:0] sr_hi;
        logic           x;
        logic           err;
        logic [DW-1:0]  ext_res;
    } state_t;

    state_t st_q, st_d;

    logic [NFLG-1:0] cur_flags, new_flags, merged;
    logic            cur_known, new_known;
    logic [DW-1:0]   alu_res;
    logic            alu_x;
    logic [3:0]      alu_cls;
    logic            sr_go, ext_go, rec_go, fl_go;

    // Live flags from the pending record.
    ccr_flag_eval #(.DW(DW)) u_cur_eval (
        .cls   (st_q.cls),
        .src   (st_q.src),
        .res   (st_q.res),
        .flags (cur_flags),
        .known (cur_known)
    );

    ccr_ext_alu #(.DW(DW)) u_ext_alu (
        .op_a  (ext_a),
        .op_b  (ext_b),
        .sub   (ext_sub),
        .x_in  (st_q.x),
        .res   (alu_res),
        .x_out (alu_x),
        .cls   (alu_cls)
    );

    // Flags of the extended result, before the sticky-Z merge.
    ccr_flag_eval #(.DW(DW)) u_ext_eval (
        .cls   (alu_cls),
        .src   (ext_b),
        .res   (alu_res),
        .flags (new_flags),
        .known (new_known)
    );

    always_comb begin
        sr_go  = sr_wr_valid;
        ext_go = ext_valid && !sr_wr_valid;
        rec_go = rec_valid && !sr_wr_valid && !ext_valid;
        fl_go  = flush_valid && !sr_wr_valid && !ext_valid && !rec_valid;

        merged        = new_known ? new_flags : cur_flags;
        merged[FLG_Z] = new_flags[FLG_Z] & cur_flags[FLG_Z];

        st_d     = st_q;
        st_d.err = 1'b0;
        if (sr_go) begin
            st_d.sr_hi = sr_wr_data[SRW-1:SR_X+1];
            st_d.x     = sr_wr_data[SR_X];
            st_d.cls   = CLS_DIRECT;
            st_d.src   = '0;
            st_d.res   = DW'(sr_wr_data[NFLG-1:0]);
        end else if (ext_go) begin
            st_d.cls     = CLS_DIRECT;
            st_d.src     = '0;
            st_d.res     = DW'(merged);
            st_d.x       = alu_x;
            st_d.ext_res = alu_res;
        end else if (rec_go) begin
            if (class_known(rec_class)) begin
                st_d.cls = rec_class;
                st_d.src = rec_src;
                st_d.res = rec_res;
            end else begin
                st_d.err = 1'b1;
            end
        end else if (fl_go && cur_known) begin
            st_d.cls = CLS_DIRECT;
            st_d.src = '0;
            st_d.res = DW'(cur_flags);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o  = {st_q.sr_hi, st_q.x, cur_flags};
    assign ext_res_o = st_q.ext_res;
    assign err_o     = st_q.err;

    // R9: once Z is clear, an extended operation cannot set it again
    a_r9_sticky_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_go && !status_o[FLG_Z]) |=> !status_o[FLG_Z]);

    // R10: upper status bits move only on a status write
    a_r10_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_wr_valid |=> $stable(status_o[SRW-1:SR_X+1]));

    // R8: X is touched only by status writes and extended operations
    a_r8_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_wr_valid && !ext_valid) |=> $stable(status_o[SR_X]));

    // R11: a bad class code is rejected and flagged
    a_r11_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_go && !class_known(rec_class)) |=> (err_o && $stable(status_o)));

    // R12: a flush does not change the visible flags
    a_r12_flush_same: assert property (@(posedge clk) disable iff (!rst_n)
        fl_go |=> $stable(status_o));
endmodule

// File: tb/ccr_lazy_eval_bench.sv
`timescale 1ns/1ps
module ccr_lazy_eval_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_wr_valid = 1'b0;
    logic [15:0] sr_wr_data = '0;
    logic        ext_valid = 1'b0;
    logic        ext_sub = 1'b0;
    logic [31:0] ext_a = '0;
    logic [31:0] ext_b = '0;
    logic        rec_valid = 1'b0;
    logic [3:0]  rec_class = '0;
    logic [31:0] rec_src = '0;
    logic [31:0] rec_res = '0;
    logic        flush_valid = 1'b0;
    logic [15:0] status_o;
    logic [31:0] ext_res_o;
    logic        err_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [10:0] e_hi = '0;
    logic        e_x = 1'b0;
    logic [3:0]  e_f = '0;

    always #4 clk = ~clk;

    ccr_lazy_eval u_ccr_lazy_eval (
        .clk, .rst_n, .sr_wr_valid, .sr_wr_data, .ext_valid, .ext_sub,
        .ext_a, .ext_b, .rec_valid, .rec_class, .rec_src, .rec_res,
        .flush_valid, .status_o, .ext_res_o, .err_o
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference flags {N,Z,V,C} for op_a + op_b + cin at width w.
    function automatic logic [3:0] f_add(input logic [31:0] a, input logic [31:0] b,
                                         input logic cin, input int w);
        logic [63:0] m, s, r;
        logic c, v, z, n;
        m = (64'd1 << w) - 64'd1;
        s = ({32'd0, a} & m) + ({32'd0, b} & m) + {63'd0, cin};
        r = s & m;
        c = s[w];
        v = (a[w-1] == b[w-1]) && (r[w-1] != a[w-1]);
        z = (r == 64'd0);
        n = !z && r[w-1];
        return {n, z, v, c};
    endfunction

    // Reference flags {N,Z,V,C} for op_a - op_b - bin at width w.
    function automatic logic [3:0] f_sub(input logic [31:0] a, input logic [31:0] b,
                                         input logic bin, input int w);
        logic [63:0] m, r;
        logic c, v, z, n;
        m = (64'd1 << w) - 64'd1;
        r = (({32'd0, a} & m) - ({32'd0, b} & m) - {63'd0, bin}) & m;
        c = ({32'd0, a} & m) < (({32'd0, b} & m) + {63'd0, bin});
        v = (a[w-1] != b[w-1]) && (r[w-1] != a[w-1]);
        z = (r == 64'd0);
        n = !z && r[w-1];
        return {n, z, v, c};
    endfunction

    function automatic logic [31:0] exp_status();
        return {16'd0, e_hi, e_x, e_f};
    endfunction

    task automatic rec(input string tag, input logic [3:0] c, input logic [31:0] s,
                       input logic [31:0] r, input logic [3:0] ef);
        rec_valid = 1'b1; rec_class = c; rec_src = s; rec_res = r;
        @(negedge clk);
        rec_valid = 1'b0;
        e_f = ef;
        chk(tag, {16'd0, status_o}, exp_status());
    endtask

    task automatic wr_sr(input logic [15:0] v);
        sr_wr_valid = 1'b1; sr_wr_data = v;
        @(negedge clk);
        sr_wr_valid = 1'b0;
        e_hi = v[15:5]; e_x = v[4]; e_f = v[3:0];
    endtask

    task automatic ext_op(input string tag, input logic sub, input logic [31:0] a,
                          input logic [31:0] b);
        logic [3:0]  f;
        logic [31:0] r;
        f = sub ? f_sub(a, b, e_x, 32) : f_add(a, b, e_x, 32);
        r = sub ? (a - b - {31'd0, e_x}) : (a + b + {31'd0, e_x});
        f[2] = f[2] & e_f[2];
        ext_valid = 1'b1; ext_sub = sub; ext_a = a; ext_b = b;
        @(negedge clk);
        ext_valid = 1'b0;
        e_f = f; e_x = f[0];
        chk({tag, " status"}, {16'd0, status_o}, exp_status());
        chk({tag, " result"}, ext_res_o, r);
    endtask

    task automatic t_reset();
        chk("R1 status", {16'd0, status_o}, 32'd0);
        chk("R1 ext_res", ext_res_o, 32'd0);
        chk("R1 err", {31'd0, err_o}, 32'd0);
    endtask

    task automatic t_nz_logic();
        rec("R2 logic zero", 4'd1, 32'hDEAD_BEEF, 32'd0, 4'b0100);
        rec("R2 logic neg", 4'd1, 32'd7, 32'h8000_0000, 4'b1000);
        rec("R2 logic pos", 4'd1, 32'hFFFF_FFFF, 32'd1, 4'b0000);
    endtask

    task automatic t_add();
        logic [31:0] a [4] = '{32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'd3};
        logic [31:0] b [4] = '{32'd1, 32'd1, 32'h8000_0000, 32'd4};
        for (int i = 0; i < 4; i++)
            rec("R3 add", 4'd2, b[i], a[i] + b[i], f_add(a[i], b[i], 1'b0, 32));
    endtask

    task automatic t_sub();
        logic [31:0] a [4] = '{32'd0, 32'h8000_0000, 32'd5, 32'h7FFF_FFFF};
        logic [31:0] b [4] = '{32'd1, 32'd1, 32'd5, 32'hFFFF_FFFF};
        for (int i = 0; i < 4; i++)
            rec("R4 sub", 4'd3, b[i], a[i] - b[i], f_sub(a[i], b[i], 1'b0, 32));
    endtask

    task automatic t_cmp();
        logic [31:0] a [3] = '{32'h1234_5680, 32'hFFFF_FF00, 32'h0000_7F05};
        logic [31:0] b [3] = '{32'hAB00_0001, 32'h0000_0001, 32'h7700_0005};
        logic [31:0] c [3] = '{32'h0001_8000, 32'hAAAA_1234, 32'h0000_0000};
        logic [31:0] d [3] = '{32'h0000_0001, 32'h5555_1234, 32'h0000_8000};
        for (int i = 0; i < 3; i++)
            rec("R5 cmp byte", 4'd4, b[i], a[i] - b[i], f_sub(a[i], b[i], 1'b0, 8));
        for (int i = 0; i < 3; i++)
            rec("R5 cmp word", 4'd5, d[i], c[i] - d[i], f_sub(c[i], d[i], 1'b0, 16));
    endtask

    task automatic t_xcls();
        rec("R6 addx carry", 4'd6, 32'd0, 32'hFFFF_FFFF + 32'd1,
            f_add(32'hFFFF_FFFF, 32'd0, 1'b1, 32));
        rec("R6 addx ovf", 4'd6, 32'h0000_0000, 32'h8000_0000,
            f_add(32'h7FFF_FFFF, 32'd0, 1'b1, 32));
        rec("R6 subx equal", 4'd7, 32'd9, 32'd9 - 32'd9 - 32'd1,
            f_sub(32'd9, 32'd9, 1'b1, 32));
        rec("R6 subx ovf", 4'd7, 32'd0, 32'h7FFF_FFFF,
            f_sub(32'h8000_0000, 32'd0, 1'b1, 32));
    endtask

    task automatic t_shift();
        rec("R7 shift carry zero", 4'd8, 32'd1, 32'd0, 4'b0101);
        rec("R7 shift neg nocarry", 4'd8, 32'd0, 32'h8000_0000, 4'b1000);
        rec("R7 shift big src", 4'd8, 32'h8000_0000, 32'd2, 4'b0001);
    endtask

    task automatic t_ext();
        wr_sr(16'h0000);
        ext_op("R8 add x0", 1'b0, 32'hFFFF_FFFF, 32'd2);
        ext_op("R8 add x1", 1'b0, 32'h7FFF_FFFF, 32'd0);
        ext_op("R8 sub x0", 1'b1, 32'd3, 32'd5);
        ext_op("R8 sub x1", 1'b1, 32'd5, 32'd5);
        chk("R8 x after borrow", {31'd0, status_o[4]}, 32'd1);
    endtask

    task automatic t_chain();
        wr_sr(16'h0004);
        ext_op("R9 zero keeps Z", 1'b0, 32'd0, 32'd0);
        chk("R9 Z held", {31'd0, status_o[2]}, 32'd1);
        ext_op("R9 nonzero clears Z", 1'b0, 32'd5, 32'd3);
        ext_op("R9 zero after nonzero", 1'b0, 32'd0, 32'd0);
        chk("R9 Z stays clear", {31'd0, status_o[2]}, 32'd0);
        wr_sr(16'h0014);
        ext_op("R9 subx to zero", 1'b1, 32'd6, 32'd5);
        chk("R9 Z set through chain", {31'd0, status_o[2]}, 32'd1);
        wr_sr(16'h0010);
        ext_op("R9 zero but Z was clear", 1'b1, 32'd6, 32'd5);
        chk("R9 Z not set", {31'd0, status_o[2]}, 32'd0);
    endtask

    task automatic t_status();
        wr_sr(16'hABCD);
        chk("R10 status load", {16'd0, status_o}, 32'h0000_ABCD);
        rec("R10 logic keeps upper", 4'd1, 32'd0, 32'd0, 4'b0100);
        chk("R10 merged value", {16'd0, status_o}, 32'h0000_ABC4);
        rec("R10 direct flags", 4'd0, 32'd0, 32'hFFFF_FFF3, 4'b0011);
    endtask

    task automatic t_bad();
        rec("R2 setup", 4'd2, 32'd1, 32'd0, f_add(32'hFFFF_FFFF, 32'd1, 1'b0, 32));
        rec("R11 class 9 no change", 4'd9, 32'd0, 32'h8000_0000, e_f);
        chk("R11 err pulse", {31'd0, err_o}, 32'd1);
        @(negedge clk);
        chk("R11 err drops", {31'd0, err_o}, 32'd0);
        rec("R11 class 15 no change", 4'd15, 32'd1, 32'd0, e_f);
        chk("R11 err pulse 15", {31'd0, err_o}, 32'd1);
    endtask

    task automatic t_flush();
        rec("R12 setup", 4'd3, 32'd1, 32'h8000_0000 - 32'd1,
            f_sub(32'h8000_0000, 32'd1, 1'b0, 32));
        flush_valid = 1'b1;
        @(negedge clk);
        flush_valid = 1'b0;
        chk("R12 flush same", {16'd0, status_o}, exp_status());
        ext_op("R12 ext after flush", 1'b0, 32'd1, 32'd1);
    endtask

    task automatic t_priority();
        e_hi = 11'h123; e_x = 1'b0; e_f = 4'b1001;
        sr_wr_valid = 1'b1; sr_wr_data = {11'h123, 1'b0, 4'b1001};
        ext_valid = 1'b1; ext_sub = 1'b0; ext_a = 32'd1; ext_b = 32'd1;
        rec_valid = 1'b1; rec_class = 4'd1; rec_src = 32'd0; rec_res = 32'd0;
        @(negedge clk);
        sr_wr_valid = 1'b0; ext_valid = 1'b0; rec_valid = 1'b0;
        chk("R13 write wins", {16'd0, status_o}, exp_status());
        ext_valid = 1'b1; ext_a = 32'd0; ext_b = 32'd0;
        rec_valid = 1'b1; rec_class = 4'd1; rec_res = 32'h8000_0000;
        @(negedge clk);
        ext_valid = 1'b0; rec_valid = 1'b0;
        e_f = 4'b0000;
        chk("R13 ext over record", {16'd0, status_o}, exp_status());
        chk("R13 ext result", ext_res_o, 32'd0);
        rec_valid = 1'b1; rec_class = 4'd1; rec_res = 32'd0;
        flush_valid = 1'b1;
        @(negedge clk);
        rec_valid = 1'b0; flush_valid = 1'b0;
        e_f = 4'b0100;
        chk("R13 record over flush", {16'd0, status_o}, exp_status());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nz_logic();
        t_add();
        t_sub();
        t_cmp();
        t_xcls();
        t_shift();
        t_ext();
        t_chain();
        t_status();
        t_bad();
        t_flush();
        t_priority();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule